// File: doc/BRIEF.md
# Encoded-Ratio Switching Clock Divider

This block derives the switching clock for a Class D output stage from the system clock. A 3-bit code picks one of eight fixed division ratios: 1, 2, 3, 4, 6, 8, 12 or 16. The set includes an odd ratio and ratios that are not powers of two. The ÷1 code passes the system clock straight through.

The downstream stage is hurt by two things: a clock that stops while it runs, and a clock whose rate shifts mid-stream, which gives an audible click. For that reason the ratio code and the enable are first copied into shadow registers. A new setting takes effect only at the start of an output period, and only while the speaker-active flag is low. The divider reports the ratio it is actually using. It also raises a flag when that ratio puts the output outside the 700 kHz to 800 kHz window, given the system clock frequency set as a parameter.

Top module: `swclk_div`

## Requirements
- R1: The ratio code maps 000→÷1, 001→÷2, 010→÷3, 011→÷4, 100→÷6, 101→÷8, 110→÷12, 111→÷16. With the block enabled and settled, the output repeats every N system-clock cycles.
- R2: During and after reset, `applied_sel` reads 111, the block is disabled and `sw_clk` is low.
- R3: For N ≥ 2 the output is high for floor(N/2) cycles and low for the rest of the period, starting high at a period start. For N = 1 the output equals the system clock.
- R4: A new ratio or enable value takes effect only at a period boundary. This is the cycle after the last cycle of a period, or any cycle while disabled. Every high and low phase on the output is therefore a whole phase of the old or the new ratio, with no runt pulses.
- R5: While `spk_active` is high, changes to `ratio_sel` are ignored. `applied_sel` and the output period keep their values until a boundary is reached with `spk_active` low.
- R6: Once the block is disabled, the output is held low. Deasserting `enable` while `spk_active` is high has no effect: the output keeps running.
- R7: `out_of_range` is high exactly when SYS_HZ / N for the applied ratio lies below F_MIN_HZ or above F_MAX_HZ. With the default 12 MHz clock, only ÷16 is in range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 3 | Requested ratio code |
| enable | input | 1 | Requested run state of the switching clock |
| spk_active | input | 1 | High while the speaker output is active; holds off changes |
| sw_clk | output | 1 | Divided switching clock |
| applied_sel | output | 3 | Ratio code currently in use |
| out_of_range | output | 1 | Applied ratio gives a frequency outside the target window |

## Verification
The hardest case to reach from the ports is a request that arrives in mid-period and must wait through one or more boundaries while `spk_active` is high. A related case is a move into or out of the ÷1 pass-through, where a careless selection would cut a phase short. The bench reaches both with a long stretch of random stimulus. It changes the ratio code, the enable and `spk_active` on independent random negative edges, so requests land at every phase of every ratio. A behavioural model is compared against the output in both halves of every clock cycle. Directed phases then measure the period and high time of each ratio, and check the hold-off and disable rules in isolation.

// File: rtl/swclk_div.sv
module swclk_div #(
  parameter int unsigned SYS_HZ   = 12_000_000,
  parameter int unsigned F_MIN_HZ = 700_000,
  parameter int unsigned F_MAX_HZ = 800_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] ratio_sel,
  input  logic       enable,
  input  logic       spk_active,
  output logic       sw_clk,
  output logic [2:0] applied_sel,
  output logic       out_of_range
);
  localparam int MAXN = 16;
  localparam int CW   = $clog2(MAXN);

  function automatic logic [CW:0] ratio_of(input logic [2:0] s);
    case (s)
      3'd0: ratio_of = (CW+1)'(1);
      3'd1: ratio_of = (CW+1)'(2);
      3'd2: ratio_of = (CW+1)'(3);
      3'd3: ratio_of = (CW+1)'(4);
      3'd4: ratio_of = (CW+1)'(6);
      3'd5: ratio_of = (CW+1)'(8);
      3'd6: ratio_of = (CW+1)'(12);
      default: ratio_of = (CW+1)'(16);
    endcase
  endfunction

  logic [2:0]    sel_sh, cur_sel;
  logic          en_sh, run_q, div_q, bypass_q;
  logic [CW-1:0] cnt;
  logic [CW:0]   n_cur, n_new, cnt_inc;
  logic          boundary, load;

  assign n_cur    = ratio_of(cur_sel);
  assign n_new    = ratio_of(sel_sh);
  assign cnt_inc  = {1'b0, cnt} + 1'b1;
  assign boundary = !run_q || ({1'b0, cnt} == n_cur - 1'b1);
  assign load     = boundary && !spk_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_sh   <= 3'b111;
      cur_sel  <= 3'b111;
      en_sh    <= 1'b0;
      run_q    <= 1'b0;
      cnt      <= '0;
      div_q    <= 1'b0;
      bypass_q <= 1'b0;
    end else begin
      sel_sh <= ratio_sel;
      en_sh  <= enable;
      if (load) begin
        cur_sel  <= sel_sh;
        run_q    <= en_sh;
        cnt      <= '0;
        div_q    <= en_sh && (n_new > 1);
        bypass_q <= en_sh && (n_new == 1);
      end else if (boundary) begin
        cnt      <= '0;
        div_q    <= run_q && (n_cur > 1);
        bypass_q <= run_q && (n_cur == 1);
      end else begin
        cnt   <= cnt + 1'b1;
        div_q <= cnt_inc < (n_cur >> 1);
      end
    end
  end

  assign sw_clk      = (bypass_q & clk) | div_q;
  assign applied_sel = cur_sel;

  logic [63:0] lo_lim, hi_lim;
  assign lo_lim       = 64'(F_MIN_HZ) * 64'(n_cur);
  assign hi_lim       = 64'(F_MAX_HZ) * 64'(n_cur);
  assign out_of_range = (64'(SYS_HZ) < lo_lim) || (64'(SYS_HZ) > hi_lim);

  p_cnt_in_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> ({1'b0, cnt} < n_cur));
  p_bypass_only_div1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_q |-> (cur_sel == 3'd0 && run_q && !div_q));
  p_switch_at_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> ($stable(cur_sel) && $stable(run_q)));
  p_hold_while_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    spk_active |=> ($stable(cur_sel) && $stable(run_q)));
  p_stop_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> ($past(boundary) && !div_q && !bypass_q));
endmodule

// File: tb/test_swclk_div.sv
`timescale 1ns/1ps
module test_swclk_div;
  localparam int CLK_P = 8;
  localparam int Q = CLK_P / 4;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, spk_active = 1'b0;
  logic [2:0] ratio_sel = 3'b111;
  logic sw_clk, out_of_range;
  logic [2:0] applied_sel;

  swclk_div i_swclk_div (.clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .enable(enable),
    .spk_active(spk_active), .sw_clk(sw_clk), .applied_sel(applied_sel), .out_of_range(out_of_range));

  always #(CLK_P/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  function automatic int ratio_n(input int s);
    int t[8] = '{1, 2, 3, 4, 6, 8, 12, 16};
    return t[s];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model: position within the period and the settings in use
  int m_pos = 0, m_sel = 7, m_shsel = 7, m_n = 16;
  bit m_run = 0, m_shen = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = 0; m_sel = 7; m_shsel = 7; m_run = 0; m_shen = 0; m_n = 16;
    end else begin
      bit at_start;
      at_start = !m_run || (m_pos == m_n - 1);
      if (at_start) begin
        if (!spk_active) begin m_sel = m_shsel; m_run = m_shen; end
        m_pos = 0;
      end else m_pos++;
      m_n = ratio_n(m_sel);
      m_shsel = ratio_sel;
      m_shen = enable;
    end
  end

  function automatic bit model_out(input bit high_half);
    if (!m_run) return 0;
    if (m_n == 1) return high_half;
    return m_pos < m_n / 2;
  endfunction

  // sampling in both halves of each cycle, plus period and high-time tracking
  int hs = 0, last_rise = -1, period_hs = 0, hi_run = 0, high_hs = 0, high_count = 0;
  bit prev = 0;
  task automatic sample(input bit high_half);
    bit v;
    v = sw_clk;
    if (rst_n) check("R4 model compare", v, model_out(high_half));
    hs++;
    if (v && !prev) begin
      if (last_rise >= 0) period_hs = hs - last_rise;
      last_rise = hs;
      hi_run = 0;
    end
    if (v) begin hi_run++; high_count++; end
    if (!v && prev) high_hs = hi_run;
    prev = v;
  endtask
  always begin
    @(posedge clk); #(Q); sample(1);
    @(negedge clk); #(Q); sample(0);
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    if (!done) begin
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    cycles(3);
    #(Q);
    check("R2 reset applied_sel", applied_sel, 7);
    check("R2 reset sw_clk", sw_clk, 0);
    check("R7 reset range flag", out_of_range, 0);
    @(negedge clk); rst_n = 1;
    cycles(40);
    check("R2 disabled after reset", high_count, 0);

    enable = 1;
    for (int s = 0; s < 8; s++) begin
      int n;
      n = ratio_n(s);
      ratio_sel = 3'(s);
      cycles(4 * n + 40);
      check("R1 applied code", applied_sel, s);
      check("R1 period", period_hs, 2 * n);
      check("R3 high time", high_hs, (n == 1) ? 1 : 2 * (n / 2));
      check("R7 range flag", out_of_range, (n == 16) ? 0 : 1);
    end

    ratio_sel = 3'd5; cycles(60);
    spk_active = 1; ratio_sel = 3'd2; cycles(100);
    check("R5 code held", applied_sel, 5);
    check("R5 period held", period_hs, 16);
    spk_active = 0; cycles(40);
    check("R5 applied after release", applied_sel, 2);
    check("R5 new period", period_hs, 6);

    spk_active = 1; enable = 0; cycles(60);
    high_count = 0; cycles(30);
    check("R6 disable ignored while active", (high_count > 0) ? 1 : 0, 1);
    check("R6 period kept", period_hs, 6);
    spk_active = 0; cycles(10);
    high_count = 0; cycles(60);
    check("R6 held low when off", high_count, 0);
    enable = 1; cycles(20);

    ratio_sel = 3'd0; cycles(20);
    ratio_sel = 3'd7; cycles(50);
    check("R4 leave bypass", period_hs, 32);
    ratio_sel = 3'd0; cycles(20);
    check("R4 enter bypass", period_hs, 2);

    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 9) == 0) ratio_sel = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 14) == 0) spk_active = ~spk_active;
      if ($urandom_range(0, 39) == 0) enable = ~enable;
    end
    cycles(5);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule